// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the bit-level engine of an SPI controller working as bus master. It takes transmit words from a ready/valid source, normally the output of a transmit FIFO. It shifts each word out on the serial data output and assembles the serial data input into a receive word. The receive word is presented with a single-cycle valid strobe. Serial clock timing comes from a programmable divider of the system clock. Up to four slave-select lines are asserted around each word.

Static configuration inputs set the following:
- clock polarity and clock phase
- which serial clock edge captures input data, chosen independently of the phase
- bit order and word length (8, 16 or 32 bits)
- per-line slave-select enable and polarity
- burst mode, which keeps slave-select asserted across consecutive words while data keeps arriving

A sticky error flag reports receive overflow and burst underflow. Clearing the enable input aborts the current transfer at once.

Top module: `spi_shift_master`

## Requirements
- R1: `cfgWidth` selects the word length: code 1 gives 16 bits, code 2 gives 32 bits, and code 0 gives 8 bits. The reserved code 3 also behaves as 8 bits. A word therefore has 2×N serial clock edges, where N is the word length.
- R2: With `cfgMsbFirst`=1, bit N-1 of a word is sent first and the first received bit lands in rxData bit N-1. With `cfgMsbFirst`=0, bit 0 goes first in both directions.
- R3: `sclk` rests at `cfgCpol` whenever no transfer is active. During a transfer it toggles once every `cfgDiv`+1 system clock cycles.
- R4: With `cfgCpha`=0, the first data bit is on `sdo` before the first `sclk` edge, and each later bit appears at an even-numbered edge. With `cfgCpha`=1, bit k appears at edge 2k+1. `sdo` is 0 while idle.
- R5: `sdi` is captured on odd-numbered edges when `cfgCpha` equals `cfgSampleSame`, and on even-numbered edges otherwise. So `cfgSampleSame`=0 captures on the edge that does not launch data, and 1 captures on the launching edge.
- R6: Each `ssOut[i]` shows `cfgSsPol[i]` while a transfer is active and `cfgSsEnable[i]`=1; otherwise it shows the inverse of `cfgSsPol[i]` (1 in `cfgSsPol[i]` means active high). Assertion leads the first edge by one half period and outlasts the last edge by one half period.
- R7: In burst mode, when a word ends and `txValid` is high, the next word is taken without slave-select dropping. Without burst mode, the block goes idle for at least one cycle between words.
- R8: `rxValid` pulses for exactly one cycle, in the cycle after the last edge of a word. `rxData` holds the received word with the bits above N cleared, until the next word completes.
- R9: `xferError` is set in two cases: when `rxValid` is high while `rxReady` is low (overflow), and when a burst word ends with no `txValid` (underflow). It stays set until `errClear` is high in a cycle with no new error.
- R10: Low `cfgEnable` returns the block to idle on the next clock. Slave-selects deassert, `sclk` goes to its rest level, no `rxValid` is produced, and the aborted word is lost.
- R11: `txReady` is high only while enabled, and only when idle or at the final half-period tick of a burst word. A transfer word is taken when `txValid` and `txReady` are both high. `busy` is high from the cycle after that until the word ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Engine enable; low aborts |
| cfgCpol | input | 1 | Serial clock rest level |
| cfgCpha | input | 1 | Clock phase |
| cfgSampleSame | input | 1 | Capture input on the launching edge when 1 |
| cfgMsbFirst | input | 1 | Bit order, 1 = most significant first |
| cfgWidth | input | 2 | Word length code |
| cfgDiv | input | DIV_W | Half-period length minus one, in system cycles |
| cfgSsEnable | input | NUM_SS | Per-line slave-select enable |
| cfgSsPol | input | NUM_SS | Per-line slave-select active level |
| cfgBurst | input | 1 | Hold slave-select across words |
| txData | input | 32 | Transmit word |
| txValid | input | 1 | Transmit word available |
| txReady | output | 1 | Transmit word accepted this cycle when valid |
| rxData | output | 32 | Last received word |
| rxValid | output | 1 | Single-cycle received-word strobe |
| rxReady | input | 1 | Receive sink can accept |
| errClear | input | 1 | Clears the error flag |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ssOut | output | NUM_SS | Slave-select lines |
| busy | output | 1 | Transfer in progress |
| xferError | output | 1 | Sticky overflow/underflow flag |

## Verification
The properties assume that polarity, phase, sampling edge, width, divider and bit order do not change while `busy` is high. Under that assumption, the rest level of `sclk` and the deasserted level of the slave-selects can be tied to `busy` alone. The stimulus therefore changes configuration only at falling clock edges after the block has gone idle. The one exception is `cfgEnable`, which is dropped mid-word to exercise the abort. `sdi` is driven with fresh random bits every cycle, so each sampling-edge choice sees a different bit on each candidate edge.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int SPI_DATA_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } spiState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic launch;
    logic sample;
    logic finish;
    logic abort;
  } spiStrobe_t;

  // word-length code to bit count; the reserved code falls back to 8
  function automatic int unsigned wordBits(input logic [1:0] code);
    case (code)
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int EDGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgCpha,
  input  logic              cfgSampleSame,
  input  logic              cfgBurst,
  input  logic [DIV_W-1:0]  cfgDiv,
  input  logic [EDGE_W-1:0] lastEdge,
  input  logic              txValid,
  output logic              txReady,
  input  logic              rxValid,
  input  logic              rxReady,
  input  logic              errClear,
  output spiStrobe_t        stb,
  output logic              active,
  output logic              sclkPhase,
  output logic              xferError
);

  spiState_e         state;
  logic [DIV_W-1:0]  divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] nextEdge;
  logic              tick;
  logic              edgeStb;
  logic              popNow;
  logic              underflow;
  logic              overflow;

  assign active    = (state != ST_IDLE);
  assign tick      = active && (divCnt == cfgDiv);
  assign nextEdge  = edgeCnt + 1'b1;
  assign edgeStb   = tick && ((state == ST_LEAD) || (state == ST_SHIFT));
  assign txReady   = cfgEnable &&
                     ((state == ST_IDLE) || ((state == ST_TRAIL) && tick && cfgBurst));
  assign popNow    = txReady && txValid;
  assign underflow = cfgEnable && (state == ST_TRAIL) && tick && cfgBurst && !txValid;
  assign overflow  = rxValid && !rxReady;

  always_comb begin
    stb.load   = popNow;
    stb.sample = edgeStb && (nextEdge[0] == (cfgCpha == cfgSampleSame));
    stb.launch = edgeStb && (cfgCpha ? (nextEdge[0] && (nextEdge != EDGE_W'(1)))
                                     : (!nextEdge[0] && (nextEdge != lastEdge)));
    stb.finish = edgeStb && (nextEdge == lastEdge);
    stb.abort  = !cfgEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else if (!cfgEnable) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      edgeCnt   <= '0;
      sclkPhase <= 1'b0;
    end else begin
      if ((state == ST_IDLE) || tick) divCnt <= '0;
      else                            divCnt <= divCnt + 1'b1;
      if (edgeStb) begin
        edgeCnt   <= nextEdge;
        sclkPhase <= ~sclkPhase;
      end
      case (state)
        ST_IDLE: if (popNow) begin
          state   <= ST_LEAD;
          edgeCnt <= '0;
        end
        ST_LEAD:  if (tick) state <= ST_SHIFT;
        ST_SHIFT: if (tick && (nextEdge == lastEdge)) state <= ST_TRAIL;
        ST_TRAIL: if (tick) begin
          state   <= popNow ? ST_LEAD : ST_IDLE;
          edgeCnt <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // new errors win over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xferError <= 1'b0;
    else       xferError <= (xferError && !errClear) || underflow || overflow;
  end

endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EDGE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic              active,
  input  logic              cfgMsbFirst,
  input  logic [EDGE_W-1:0] nBits,
  input  logic [DATA_W-1:0] txData,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] txWord;
  logic [DATA_W-1:0] rxAcc;
  logic [DATA_W-1:0] rxNext;
  logic [IDX_W-1:0]  txIdx;
  logic [IDX_W-1:0]  rxIdx;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  txPos;
  logic [IDX_W-1:0]  rxPos;

  assign topIdx = IDX_W'(nBits - 1'b1);
  assign txPos  = cfgMsbFirst ? (topIdx - txIdx) : txIdx;
  assign rxPos  = cfgMsbFirst ? (topIdx - rxIdx) : rxIdx;
  assign sdo    = active && txWord[txPos];

  always_comb begin
    rxNext = rxAcc;
    if (stb.sample) rxNext[rxPos] = sdi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord  <= '0;
      txIdx   <= '0;
      rxAcc   <= '0;
      rxIdx   <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else if (stb.abort) begin
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.finish;
      if (stb.load) begin
        txWord <= txData;
        txIdx  <= '0;
        rxAcc  <= '0;
        rxIdx  <= '0;
      end else begin
        if (stb.launch) txIdx <= txIdx + 1'b1;
        if (stb.sample) begin
          rxAcc <= rxNext;
          rxIdx <= rxIdx + 1'b1;
        end
        if (stb.finish) rxData <= rxNext;
      end
    end
  end

endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_shift_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int NUM_SS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEnable,
  input  logic                  cfgCpol,
  input  logic                  cfgCpha,
  input  logic                  cfgSampleSame,
  input  logic                  cfgMsbFirst,
  input  logic [1:0]            cfgWidth,
  input  logic [DIV_W-1:0]      cfgDiv,
  input  logic [NUM_SS-1:0]     cfgSsEnable,
  input  logic [NUM_SS-1:0]     cfgSsPol,
  input  logic                  cfgBurst,
  input  logic [SPI_DATA_W-1:0] txData,
  input  logic                  txValid,
  output logic                  txReady,
  output logic [SPI_DATA_W-1:0] rxData,
  output logic                  rxValid,
  input  logic                  rxReady,
  input  logic                  errClear,
  output logic                  sclk,
  output logic                  sdo,
  input  logic                  sdi,
  output logic [NUM_SS-1:0]     ssOut,
  output logic                  busy,
  output logic                  xferError
);

  localparam int EDGE_W = $clog2(2 * SPI_DATA_W + 1);

  spiStrobe_t        stb;
  logic              active;
  logic              sclkPhase;
  logic [EDGE_W-1:0] nBits;
  logic [EDGE_W-1:0] lastEdge;

  assign nBits    = EDGE_W'(wordBits(cfgWidth));
  assign lastEdge = nBits << 1;
  assign sclk     = cfgCpol ^ sclkPhase;
  assign busy     = active;

  for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
    assign ssOut[g] = (active && cfgSsEnable[g]) ? cfgSsPol[g] : ~cfgSsPol[g];
  end

  spi_shift_ctrl #(.DIV_W(DIV_W), .EDGE_W(EDGE_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .cfgCpha      (cfgCpha),
    .cfgSampleSame(cfgSampleSame),
    .cfgBurst     (cfgBurst),
    .cfgDiv       (cfgDiv),
    .lastEdge     (lastEdge),
    .txValid      (txValid),
    .txReady      (txReady),
    .rxValid      (rxValid),
    .rxReady      (rxReady),
    .errClear     (errClear),
    .stb          (stb),
    .active       (active),
    .sclkPhase    (sclkPhase),
    .xferError    (xferError)
  );

  spi_shift_dp #(.DATA_W(SPI_DATA_W), .EDGE_W(EDGE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .active     (active),
    .cfgMsbFirst(cfgMsbFirst),
    .nBits      (nBits),
    .txData     (txData),
    .sdi        (sdi),
    .sdo        (sdo),
    .rxData     (rxData),
    .rxValid    (rxValid)
  );

endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int NUM_SS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic              cfgCpol,
  input logic [NUM_SS-1:0] cfgSsPol,
  input logic              txValid,
  input logic              txReady,
  input logic              rxValid,
  input logic              rxReady,
  input logic              errClear,
  input logic              sclk,
  input logic              busy,
  input logic              xferError,
  input logic [NUM_SS-1:0] ssOut
);

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclk == cfgCpol)); // R3

  AST_SS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssOut == ~cfgSsPol)); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !busy); // R10

  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R8

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (xferError && !errClear) |=> xferError); // R9

  AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> xferError); // R9

  AST_POP_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> busy); // R11

  AST_READY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> cfgEnable); // R11

endmodule

bind spi_shift_master spi_shift_master_chk #(.NUM_SS(NUM_SS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgEnable(cfgEnable),
  .cfgCpol  (cfgCpol),
  .cfgSsPol (cfgSsPol),
  .txValid  (txValid),
  .txReady  (txReady),
  .rxValid  (rxValid),
  .rxReady  (rxReady),
  .errClear (errClear),
  .sclk     (sclk),
  .busy     (busy),
  .xferError(xferError),
  .ssOut    (ssOut)
);

// File: tb/spi_shift_master_bench.sv
`timescale 1ns/1ps
module spi_shift_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgCpol = 1'b0, cfgCpha = 1'b0, cfgSampleSame = 1'b0;
  logic        cfgMsbFirst = 1'b1, cfgBurst = 1'b0;
  logic [1:0]  cfgWidth = 2'd0;
  logic [7:0]  cfgDiv = 8'd0;
  logic [3:0]  cfgSsEnable = 4'b0001, cfgSsPol = 4'b0000;
  logic [31:0] txData = 32'h0;
  logic        txValid = 1'b0, rxReady = 1'b1, errClear = 1'b0, sdi = 1'b0;
  logic        txReady, rxValid, sclk, sdo, busy, xferError;
  logic [31:0] rxData;
  logic [3:0]  ssOut;

  int nChecks = 0;
  int nErr = 0;
  int txLeft = 0;
  int cycles = 0;
  bit checking = 0;

  // reference model state
  bit          mActive, mRxValid, mErr, mPopped;
  int          mT, mN, mJ;
  logic [31:0] mWord, mAcc, mRxData;

  always #5 clk = ~clk;

  spi_shift_master u_spi_shift_master (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgSampleSame(cfgSampleSame), .cfgMsbFirst(cfgMsbFirst), .cfgWidth(cfgWidth),
    .cfgDiv(cfgDiv), .cfgSsEnable(cfgSsEnable), .cfgSsPol(cfgSsPol), .cfgBurst(cfgBurst),
    .txData(txData), .txValid(txValid), .txReady(txReady), .rxData(rxData),
    .rxValid(rxValid), .rxReady(rxReady), .errClear(errClear), .sclk(sclk), .sdo(sdo),
    .sdi(sdi), .ssOut(ssOut), .busy(busy), .xferError(xferError)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int widthBits(input logic [1:0] code);
    if (code == 2'd1) return 16;
    if (code == 2'd2) return 32;
    return 8; // R1: codes 0 and 3
  endfunction

  function automatic bit modelReady();
    int hp = int'(cfgDiv) + 1;
    return cfgEnable && (!mActive || (cfgBurst && (mT == (2 * mN + 1) * hp - 1)));
  endfunction

  task automatic modelStart();
    mActive = 1; mT = 0; mWord = txData; mAcc = '0; mJ = 0;
    mN = widthBits(cfgWidth);
    mPopped = 1;
  endtask

  // behavioural timeline model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mT = 0; mN = 8; mJ = 0; mWord = '0; mAcc = '0;
      mRxData = '0; mRxValid = 0; mErr = 0; mPopped = 0;
    end else begin
      bit pop, ovf, unf;
      int hp;
      hp  = int'(cfgDiv) + 1;
      pop = modelReady() && txValid;
      ovf = mRxValid && !rxReady;
      unf = 0;
      mRxValid = 0;
      mPopped = 0;
      if (!cfgEnable) begin
        mActive = 0;
      end else if (!mActive) begin
        if (pop) modelStart();
      end else begin
        mT++;
        if ((mT % hp == 0) && (mT / hp <= 2 * mN)) begin
          int k;
          k = mT / hp;
          if (((k % 2) == 1) == (cfgCpha == cfgSampleSame)) begin
            mAcc[cfgMsbFirst ? (mN - 1 - mJ) : mJ] = sdi;
            mJ++;
          end
          if (k == 2 * mN) begin
            mRxValid = 1;
            mRxData = mAcc;
          end
        end
        if (mT == (2 * mN + 1) * hp) begin
          if (pop) modelStart();
          else begin
            if (cfgBurst) unf = 1;
            mActive = 0;
          end
        end
      end
      mErr = (mErr && !errClear) || ovf || unf;
    end
  end

  task automatic compareAll();
    int hp, e, idx;
    logic expSdo;
    logic [3:0] expSs;
    hp = int'(cfgDiv) + 1;
    e = 0;
    if (mActive) e = (mT / hp > 2 * mN) ? 2 * mN : mT / hp;
    check("R3", "sclk", {31'b0, sclk}, {31'b0, cfgCpol ^ logic'(e % 2)});
    if (cfgCpha) idx = (e == 0) ? 0 : (e - 1) / 2;
    else         idx = (e / 2 > mN - 1) ? mN - 1 : e / 2;
    expSdo = mActive ? mWord[cfgMsbFirst ? (mN - 1 - idx) : idx] : 1'b0;
    check("R4", "sdo", {31'b0, sdo}, {31'b0, expSdo});
    for (int i = 0; i < 4; i++)
      expSs[i] = (mActive && cfgSsEnable[i]) ? cfgSsPol[i] : ~cfgSsPol[i];
    check("R6", "ssOut", {28'b0, ssOut}, {28'b0, expSs});
    check("R11", "busy", {31'b0, busy}, {31'b0, mActive});
    check("R11", "txReady", {31'b0, txReady}, {31'b0, modelReady()});
    check("R8", "rxValid", {31'b0, rxValid}, {31'b0, mRxValid});
    check("R8", "rxData", rxData, mRxData);
    check("R9", "xferError", {31'b0, xferError}, {31'b0, mErr});
  endtask

  // stimulus of the serial input and the transmit source, then comparison
  always @(negedge clk) begin
    #1;
    sdi = logic'($urandom_range(0, 1));
    if (mPopped) begin
      txLeft--;
      txData = $urandom;
    end
    txValid = (txLeft > 0);
    #1;
    if (checking) compareAll();
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nErr++;
      $display("FAIL R11 watchdog actual=running expected=idle");
      finishRun();
    end
  end

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (txLeft == 0 && !mActive) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic cpol, input logic cpha, input logic same, input logic msb,
                       input logic [1:0] w, input logic [7:0] div, input logic burst);
    @(negedge clk);
    cfgCpol = cpol; cfgCpha = cpha; cfgSampleSame = same; cfgMsbFirst = msb;
    cfgWidth = w; cfgDiv = div; cfgBurst = burst;
  endtask

  task automatic clearErr();
    @(negedge clk); errClear = 1'b1;
    @(negedge clk); errClear = 1'b0;
  endtask

  initial begin
    txData = $urandom;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #3;
    // reset state: idle, rest levels, no error (R3 R6 R8 R9 R11)
    check("R11", "reset busy", {31'b0, busy}, 32'd0);
    check("R3", "reset sclk", {31'b0, sclk}, {31'b0, cfgCpol});
    check("R6", "reset ssOut", {28'b0, ssOut}, {28'b0, ~cfgSsPol});
    check("R9", "reset error", {31'b0, xferError}, 32'd0);
    checking = 1;
    cfgEnable = 1'b1;

    // R1 R2 R4 R5: 8-bit, MSB first, phase 0, capture on non-launch edge, non-burst (R7)
    setup(0, 0, 0, 1, 2'd0, 8'd0, 0);
    txLeft = 3; waitDone(2000);

    // R2 R5 R7 R9: 16-bit LSB first, phase 1, same-edge capture, burst then underflow
    setup(1, 1, 1, 0, 2'd1, 8'd2, 1);
    cfgSsEnable = 4'b1011; cfgSsPol = 4'b0100;
    txLeft = 3; waitDone(4000);
    clearErr();

    // R1 R9: 32-bit, receive sink stalled so each word overflows
    setup(0, 1, 0, 1, 2'd2, 8'd1, 0);
    rxReady = 1'b0;
    txLeft = 2; waitDone(4000);
    rxReady = 1'b1;
    clearErr();

    // R1 R5 R6 R7: reserved width code, phase 0 same-edge capture, burst, mixed polarity
    setup(1, 0, 1, 0, 2'd3, 8'd3, 1);
    cfgSsEnable = 4'b0110; cfgSsPol = 4'b1010;
    txLeft = 2; waitDone(4000);
    clearErr();

    // R10: abort mid-word, then resume
    setup(0, 0, 0, 1, 2'd2, 8'd4, 0);
    cfgSsEnable = 4'b1111; cfgSsPol = 4'b0000;
    txLeft = 1;
    repeat (100) @(negedge clk);
    cfgEnable = 1'b0;
    repeat (3) @(negedge clk);
    cfgEnable = 1'b1;
    txLeft = 1; waitDone(4000);

    // R2 R4 R7: MSB first, phase 1, non-burst back to back
    setup(1, 1, 0, 1, 2'd1, 8'd0, 0);
    txLeft = 3; waitDone(4000);

    checking = 0;
    finishRun();
  end

endmodule